// File: doc/BRIEF.md
# Edge-Capture Interrupt Input Port

This block is a general-purpose input port of configurable width with interrupt support. Each external pin passes through a two-flop synchronizer. A detector then compares the synchronized value with its value one cycle earlier to find a chosen transition on each bit. The transition is a rising edge, a falling edge, or either, picked at build time. Each detected transition sets a sticky bit in a capture register.

A per-bit enable register decides which captured bits drive a single active-high interrupt line. Software typically enables the bits it cares about, waits for the interrupt, reads the capture register to find the source, and then clears it.

Software reaches the port through a small register bus. Reads are combinational and writes take effect at the clock edge. A build-time switch picks how the capture register is cleared: either a 1 written to a bit clears only that bit, or any write clears every bit.

Top module: `edge_irq_port`

## Requirements
- R1: Word offset 0 returns the synchronized pin levels. A pin change driven before clock edge k is readable after edge k+1.
- R2: With EDGE_SEL = 0 a 0-to-1 transition is detected, with 1 a 1-to-0 transition, and with 2 either. A detected transition on a pin driven before edge k shows as a set capture bit at offset 3 after edge k+2.
- R3: A set capture bit stays set through any number of cycles in which no write is made to offset 3. Writes to offsets 0, 1 and 2 leave it unchanged.
- R4: Offset 2 holds the per-bit interrupt enable. A write loads it and a read returns it.
- R5: With BIT_CLEAR = 1, a write to offset 3 clears exactly those capture bits where the written data is 1.
- R6: With BIT_CLEAR = 0, a write to offset 3 clears every capture bit, whatever the data.
- R7: `irq` is high exactly when some capture bit and its enable bit are both 1.
- R8: A transition detected in the same cycle as a clearing write to that bit wins, and the bit remains set.
- R9: After reset, all registers read 0 and `irq` is low. Offset 1 always reads 0. A write to offset 0 or 1 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | WIDTH | External input pins, asynchronous |
| bus_addr | input | 2 | Register word offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data for the current offset |
| irq | output | 1 | Active-high interrupt request |

## Verification
Three instances share the same stimulus and differ in build options: falling edge with per-bit clearing, falling edge with clear-all, and both edges with per-bit clearing. Because they see identical pins, a rising pin that the both-edge instance captures but the falling-edge ones ignore shows the edge selection directly. Random writes to offset 3 with partial data patterns separate per-bit clearing from clear-all. Directed cases cover:
- the reset state;
- a clearing write timed exactly on a detected edge;
- an all-zero enable pattern that must hold `irq` low;
- writes to the read-only offsets.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
    localparam int EDGE_RISE = 0;
    localparam int EDGE_FALL = 1;
    localparam int EDGE_BOTH = 2;

    typedef enum logic [1:0] {
        OFS_DATA   = 2'd0,
        OFS_UNUSED = 2'd1,
        OFS_ENABLE = 2'd2,
        OFS_CAPT   = 2'd3
    } reg_ofs_e;
endpackage

// File: rtl/edge_irq_detect.sv
module edge_irq_detect #(
    parameter int WIDTH    = 4,
    parameter int EDGE_SEL = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] hit
);
    import edge_irq_pkg::*;

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign level = sync_q;

    generate
        if (EDGE_SEL == EDGE_RISE) begin : g_rise
            assign hit = sync_q & ~prev_q;
        end else if (EDGE_SEL == EDGE_FALL) begin : g_fall
            assign hit = ~sync_q & prev_q;
        end else begin : g_both
            assign hit = sync_q ^ prev_q;
        end
    endgenerate
endmodule

// File: rtl/edge_irq_capture.sv
module edge_irq_capture #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] hit,
    input  logic             clr_en,
    input  logic [WIDTH-1:0] clr_bits,
    output logic [WIDTH-1:0] capt
);
    logic [WIDTH-1:0] capt_d;

    always_comb begin
        capt_d = capt;
        if (clr_en) begin
            capt_d = capt_d & ~clr_bits;
        end
        capt_d = capt_d | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            capt <= '0;
        end else begin
            capt <= capt_d;
        end
    end
endmodule

// File: rtl/edge_irq_port.sv
module edge_irq_port #(
    parameter int WIDTH     = 4,
    parameter int EDGE_SEL  = 1,
    parameter bit BIT_CLEAR = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    output logic             irq
);
    import edge_irq_pkg::*;

    logic [WIDTH-1:0] level;
    logic [WIDTH-1:0] hit;
    logic [WIDTH-1:0] capt;
    logic [WIDTH-1:0] enable_q;
    logic [WIDTH-1:0] clr_bits;
    logic             clr_en;
    reg_ofs_e         ofs;

    assign ofs = reg_ofs_e'(bus_addr);

    edge_irq_detect #(.WIDTH(WIDTH), .EDGE_SEL(EDGE_SEL)) u_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .level  (level),
        .hit    (hit)
    );

    assign clr_en = bus_wr && (ofs == OFS_CAPT);

    generate
        if (BIT_CLEAR) begin : g_bitclr
            assign clr_bits = bus_wdata;
        end else begin : g_allclr
            assign clr_bits = '1;
        end
    endgenerate

    edge_irq_capture #(.WIDTH(WIDTH)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .clr_en   (clr_en),
        .clr_bits (clr_bits),
        .capt     (capt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= '0;
        end else if (bus_wr && (ofs == OFS_ENABLE)) begin
            enable_q <= bus_wdata;
        end
    end

    always_comb begin
        unique case (ofs)
            OFS_DATA:   bus_rdata = level;
            OFS_ENABLE: bus_rdata = enable_q;
            OFS_CAPT:   bus_rdata = capt;
            default:    bus_rdata = '0;
        endcase
    end

    assign irq = |(capt & enable_q);
endmodule

// File: rtl/edge_irq_port_chk.sv
module edge_irq_port_chk #(
    parameter int WIDTH     = 4,
    parameter bit BIT_CLEAR = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       bus_addr,
    input logic             bus_wr,
    input logic [WIDTH-1:0] bus_wdata,
    input logic [WIDTH-1:0] hit,
    input logic [WIDTH-1:0] capt,
    input logic [WIDTH-1:0] enable_q,
    input logic             irq
);
    logic capt_wr;
    assign capt_wr = bus_wr && (bus_addr == 2'd3);

    a_r4_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd2) |=> (enable_q == $past(bus_wdata)));

    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !capt_wr |=> ((capt & $past(capt)) == $past(capt)));

    generate
        if (BIT_CLEAR) begin : g_bc
            a_r5_bit_clear: assert property (@(posedge clk) disable iff (!rst_n)
                capt_wr |=> ((capt & $past(capt) & ~$past(bus_wdata))
                             == ($past(capt) & ~$past(bus_wdata))));
        end else begin : g_ac
            a_r6_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
                capt_wr |=> (capt == $past(hit)));
        end
    endgenerate

    a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_q == '0) |-> !irq);

    a_r8_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((capt & $past(hit)) == $past(hit)));
endmodule

bind edge_irq_port edge_irq_port_chk #(.WIDTH(WIDTH), .BIT_CLEAR(BIT_CLEAR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .hit       (hit),
    .capt      (capt),
    .enable_q  (enable_q),
    .irq       (irq)
);

// File: tb/edge_irq_port_test.sv
module edge_irq_port_test;
    localparam int W = 4;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] pins = '0;
    logic [1:0]   addr = 2'd0;
    logic         wr = 1'b0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rd_b, rd_a, rd_x;
    logic         irq_b, irq_a, irq_x;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // model state
    logic [W-1:0] m_s1 = '0, m_s2 = '0, m_pv = '0;
    logic [W-1:0] m_cb = '0, m_ca = '0, m_cx = '0, m_en = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    edge_irq_port #(.WIDTH(W), .EDGE_SEL(1), .BIT_CLEAR(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .pin_in(pins), .bus_addr(addr), .bus_wr(wr),
        .bus_wdata(wdata), .bus_rdata(rd_b), .irq(irq_b));
    edge_irq_port #(.WIDTH(W), .EDGE_SEL(1), .BIT_CLEAR(1'b0)) uut_all (
        .clk(clk), .rst_n(rst_n), .pin_in(pins), .bus_addr(addr), .bus_wr(wr),
        .bus_wdata(wdata), .bus_rdata(rd_a), .irq(irq_a));
    edge_irq_port #(.WIDTH(W), .EDGE_SEL(2), .BIT_CLEAR(1'b1)) uut_any (
        .clk(clk), .rst_n(rst_n), .pin_in(pins), .bus_addr(addr), .bus_wr(wr),
        .bus_wdata(wdata), .bus_rdata(rd_x), .irq(irq_x));

    function automatic logic [W-1:0] exp_read(input logic [1:0] a, input logic [W-1:0] c);
        case (a)
            2'd0:    return m_s2;
            2'd2:    return m_en;
            2'd3:    return c;
            default: return '0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic report_summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // apply one cycle of stimulus, update model, check outputs at negedge
    task automatic step(input logic [W-1:0] p, input logic w, input logic [1:0] a,
                        input logic [W-1:0] d);
        logic [W-1:0] fall, any, clr;
        logic cw;
        pins = p; wr = w; addr = a; wdata = d;
        @(posedge clk);
        #1;
        fall = m_pv & ~m_s2;
        any  = m_pv ^ m_s2;
        cw   = w && (a == 2'd3);
        clr  = cw ? d : '0;
        m_cb = (m_cb & ~clr) | fall;
        m_ca = (cw ? '0 : m_ca) | fall;
        m_cx = (m_cx & ~clr) | any;
        if (w && a == 2'd2) m_en = d;
        m_pv = m_s2; m_s2 = m_s1; m_s1 = p;
        @(negedge clk);
        wr = 1'b0;
        #1;
        check(a == 2'd0 ? "R1 data" : a == 2'd2 ? "R4 enable" : a == 2'd3 ? "R5 capt" : "R9 offset1",
              rd_b, exp_read(a, m_cb));
        check(a == 2'd3 ? "R6 capt clear-all" : "R9 read clear-all", rd_a, exp_read(a, m_ca));
        check(a == 2'd3 ? "R2 capt both-edge" : "R9 read both-edge", rd_x, exp_read(a, m_cx));
        check("R7 irq", {{(W-1){1'b0}}, irq_b}, {{(W-1){1'b0}}, |(m_cb & m_en)});
        check("R7 irq clear-all", {{(W-1){1'b0}}, irq_a}, {{(W-1){1'b0}}, |(m_ca & m_en)});
        check("R7 irq both-edge", {{(W-1){1'b0}}, irq_x}, {{(W-1){1'b0}}, |(m_cx & m_en)});
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<=100000", cyc);
            report_summary();
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 reset irq", {{(W-1){1'b0}}, irq_b}, '0);
        addr = 2'd3; #1; check("R9 reset capt", rd_b, '0);
        addr = 2'd2; #1; check("R9 reset enable", rd_b, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // enable all, then raise pins (rising: only both-edge captures) - R2
        step('0, 1'b1, 2'd2, 4'hF);
        step(4'hF, 1'b0, 2'd0, '0);
        step(4'hF, 1'b0, 2'd0, '0);
        step(4'hF, 1'b0, 2'd3, '0);
        check("R2 rise ignored by falling-edge", rd_b, 4'h0);
        check("R2 rise caught by both-edge", rd_x, 4'hF);
        // falling on bit 0 - R2
        step(4'hE, 1'b0, 2'd3, '0);
        step(4'hE, 1'b0, 2'd3, '0);
        step(4'hE, 1'b0, 2'd3, '0);
        check("R2 fall bit0", rd_b, 4'h1);
        // R3: writes to other offsets do not clear
        step(4'hE, 1'b1, 2'd0, 4'hF);
        step(4'hE, 1'b1, 2'd1, 4'hF);
        step(4'hE, 1'b0, 2'd3, '0);
        check("R3 sticky", rd_b, 4'h1);
        // R8: edge and clear in same cycle; bit 1 falls
        step(4'hC, 1'b0, 2'd3, '0);
        step(4'hC, 1'b0, 2'd3, '0);
        step(4'hC, 1'b1, 2'd3, 4'h2);
        check("R8 edge wins", rd_b & 4'h2, 4'h2);
        // R5: clear bit 0 only
        step(4'hC, 1'b1, 2'd3, 4'h1);
        check("R5 partial clear", rd_b, 4'h2);
        // R7: enable zero keeps irq low
        step(4'hC, 1'b1, 2'd2, 4'h0);
        check("R7 disabled irq low", {{(W-1){1'b0}}, irq_b}, '0);
        // R6: clear-all with data 0
        step(4'hC, 1'b1, 2'd3, 4'h0);
        check("R6 any write clears all", rd_a, 4'h0);

        for (int i = 0; i < 400; i++) begin
            logic [W-1:0] p;
            logic w;
            p = ($urandom % 3 == 0) ? W'($urandom) : pins;
            w = ($urandom % 4 == 0);
            step(p, w, 2'($urandom), W'($urandom));
        end
        report_summary();
    end
endmodule